// File: doc/BRIEF.md
# Instruction Memory Parity Guard

This block sits beside an instruction-side memory and protects it with one even parity bit per 64-bit granule. A flag bit per granule records whether that parity bit can be trusted. The storage is a small behavioural array inside the block. Three paths reach it. A write port with a byte mask is used by a copy agent. A fetch port returns whole 256-bit lines. A copy-agent read port takes a size code. When protection is on, a full aligned write records the parity of its data and trusts it. A write that is partial or misaligned withdraws that trust. Reads of qualifying width are checked, and the first bad granule is reported for one cycle. The scheme only detects single-bit upsets and never repairs data.

Fetch requests are always accepted, and their `if_ready` is not needed. Writes are always accepted as well. The copy-agent read is a valid/ready stream. `dr_ready` is low in any cycle in which a fetch is presented. A stalled requester keeps `dr_valid`, `dr_addr` and `dr_size` stable until `dr_ready` is seen high. Both read responses appear one cycle after acceptance and cannot be back-pressured.

The granule count must be a power of two. Granule addresses wrap modulo the array size.

Top module: `ipar_guard`

## Requirements
- R1: After reset every granule's trust flag is clear, and `err_valid`, `if_rvalid` and `dr_rvalid` are 0. A reset in the middle of operation also makes every earlier recorded parity untrusted.
- R2: With `prot_en` high, a write with `wr_be == 8'hFF` and `wr_addr[2:0] == 0` stores the even parity (XOR of the 64 data bits) of granule `wr_addr >> 3` and marks it trusted.
- R3: With `prot_en` high, a write with `wr_be != 8'hFF` or `wr_addr[2:0] != 0` marks granule `wr_addr >> 3` untrusted. In every write, byte lane b (bits 8b+7:8b) of that granule takes `wr_data[8b+7:8b]` exactly when `wr_be[b]` is set.
- R4: With `prot_en` low, writes still change the data but leave parity and trust unchanged. A read accepted while `prot_en` is low never raises `err_valid`.
- R5: A fetch ignores `if_addr[4:0]`. One cycle after acceptance it returns line `if_addr >> 5` on `if_rdata` with `if_rvalid` high. Granule k of the line sits at bits 64k+63:64k. All four granules are checked.
- R6: A copy-agent read with size code s moves 2^s bytes, where codes 6 and 7 count as 5. One cycle after acceptance it returns four granules starting at `dr_addr >> 3` (wrapping) on `dr_rdata` with `dr_rvalid` high. Only the first 2^(s-3) granules are checked, and none are checked when s < 3.
- R7: An untrusted granule never raises an error, whatever its stored parity.
- R8: `err_valid` is high for one cycle, in the cycle of the read response. `err_addr` is the byte address (granule index × 8) of the first failing checked granule, counting upward from the start granule.
- R9: `dr_ready` is low whenever `if_valid` is high. At most one read is accepted per cycle, and a stalled copy-agent read is accepted in a later cycle.
- R10: A read accepted in the same cycle as a write to one of its granules returns and checks the contents, parity and trust that held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_en | input | 1 | Parity protection enable |
| wr_valid | input | 1 | Write request (always accepted) |
| wr_addr | input | 7 | Write byte address |
| wr_be | input | 8 | Write byte-lane mask |
| wr_data | input | 64 | Write data |
| if_valid | input | 1 | Fetch request (always accepted) |
| if_addr | input | 7 | Fetch byte address, low 5 bits ignored |
| if_rvalid | output | 1 | Fetch response valid |
| if_rdata | output | 256 | Fetch line data |
| dr_valid | input | 1 | Copy-agent read request valid |
| dr_ready | output | 1 | Copy-agent read request ready |
| dr_addr | input | 7 | Copy-agent read byte address |
| dr_size | input | 3 | Size code, 2^code bytes |
| dr_rvalid | output | 1 | Copy-agent read response valid |
| dr_rdata | output | 256 | Four granules from the start granule |
| err_valid | output | 1 | Parity error pulse |
| err_addr | output | 7 | Byte address of first failing granule |

## Verification
Two pairs of functions can collide in one cycle. In the first, a write and a read hit the same granule. The bench flips a bit in a granule while protection is off, then re-enables protection and presents a repairing full write together with a fetch of that line. The fetch must still report the old failure, and a repeat fetch must report none. In the second, a fetch and a copy-agent read are presented together. The bench holds the copy-agent request and judges `dr_ready`, the order of the two responses and their errors against a cycle-by-cycle behavioural model. Random mixes of all ports follow, compared against the same model.

// File: rtl/ipar_pkg.sv
package ipar_pkg;
  localparam int GRAN_BITS = 64;
  localparam int LANES     = GRAN_BITS / 8;
  localparam int LINE_GRAN = 4;
  localparam int MAX_SIZE  = 5;   // 2^5 bytes = one line
  localparam int MIN_CHECK = 3;   // 2^3 bytes = one granule

  typedef logic [GRAN_BITS-1:0] gran_t;

  function automatic logic even_par(input gran_t d);
    return ^d;
  endfunction
endpackage

// File: rtl/ipar_wclass.sv
module ipar_wclass
  import ipar_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  be,
  output logic              full
);
  // A write counts as full only when it covers a whole granule on its boundary
  assign full = (be == {LANES{1'b1}}) && (addr[2:0] == 3'b000);
endmodule

// File: rtl/ipar_store.sv
module ipar_store
  import ipar_pkg::*;
#(
  parameter int GRAN_CNT = 16,
  localparam int GIDX_W = $clog2(GRAN_CNT)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           prot_en,
  input  logic                           wr_valid,
  input  logic [GIDX_W-1:0]              wr_gidx,
  input  logic [LANES-1:0]               wr_be,
  input  gran_t                          wr_data,
  input  logic                           wr_full,
  input  logic [GIDX_W-1:0]              rd_gidx,
  output logic [LINE_GRAN-1:0][GRAN_BITS-1:0] rd_data,
  output logic [LINE_GRAN-1:0]           rd_par,
  output logic [LINE_GRAN-1:0]           rd_vld
);
  gran_t                mem [GRAN_CNT];
  logic [GRAN_CNT-1:0]  par;
  logic [GRAN_CNT-1:0]  vld;

  // Data lanes follow the mask regardless of protection state
  always_ff @(posedge clk) begin
    if (wr_valid) begin
      for (int b = 0; b < LANES; b++) begin
        if (wr_be[b]) mem[wr_gidx][8*b +: 8] <= wr_data[8*b +: 8];
      end
    end
  end

  // Only trust flags are reset; parity is meaningless while untrusted
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (wr_valid && prot_en) begin
      vld[wr_gidx] <= wr_full;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_valid && prot_en && wr_full) par[wr_gidx] <= even_par(wr_data);
  end

  // Four consecutive granules, wrapping at the top of the array
  for (genvar k = 0; k < LINE_GRAN; k++) begin : g_rd
    logic [GIDX_W-1:0] idx;
    assign idx        = rd_gidx + GIDX_W'(k);
    assign rd_data[k] = mem[idx];
    assign rd_par[k]  = par[idx];
    assign rd_vld[k]  = vld[idx];
  end

  // R2: a full write under protection leaves its granule trusted
  a_r2_full_sets_trust: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && prot_en && wr_full) |=> vld[$past(wr_gidx)]);

  // R4: writes with protection off leave every trust flag alone
  a_r4_off_keeps_trust: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !prot_en) |=> (vld == $past(vld)));

  // R3: a partial or misaligned write under protection withdraws trust
  a_r3_partial_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && prot_en && !wr_full) |=> !vld[$past(wr_gidx)]);
endmodule

// File: rtl/ipar_check.sv
module ipar_check
  import ipar_pkg::*;
#(
  parameter int GIDX_W = 4,
  localparam int ADDR_W = GIDX_W + 3,
  localparam int SEL_W  = $clog2(LINE_GRAN)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req,
  input  logic                           chk_en,
  input  logic [LINE_GRAN-1:0]           gmask,
  input  logic [GIDX_W-1:0]              start,
  input  logic [LINE_GRAN-1:0][GRAN_BITS-1:0] rd_data,
  input  logic [LINE_GRAN-1:0]           rd_par,
  input  logic [LINE_GRAN-1:0]           rd_vld,
  output logic                           err_valid,
  output logic [ADDR_W-1:0]              err_addr
);
  logic [LINE_GRAN-1:0] fail;
  logic                 hit;
  logic [SEL_W-1:0]     sel;

  for (genvar k = 0; k < LINE_GRAN; k++) begin : g_chk
    assign fail[k] = chk_en && gmask[k] && rd_vld[k] &&
                     (even_par(rd_data[k]) != rd_par[k]);
  end

  // Scan from the top so the granule nearest the start wins
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int k = LINE_GRAN - 1; k >= 0; k--) begin
      if (fail[k]) begin
        hit = 1'b1;
        sel = SEL_W'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err_addr  <= '0;
    end else begin
      err_valid <= req && hit;
      if (req && hit) err_addr <= {start + GIDX_W'(sel), 3'b000};
    end
  end

  // R8: an error pulse always answers a read accepted one cycle earlier
  a_r8_err_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> $past(req));
endmodule

// File: rtl/ipar_guard.sv
module ipar_guard
  import ipar_pkg::*;
#(
  parameter int GRAN_CNT = 16,
  localparam int GIDX_W = $clog2(GRAN_CNT),
  localparam int ADDR_W = GIDX_W + 3,
  localparam int LINE_W = LINE_GRAN * GRAN_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_en,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_be,
  input  logic [GRAN_BITS-1:0] wr_data,
  input  logic              if_valid,
  input  logic [ADDR_W-1:0] if_addr,
  output logic              if_rvalid,
  output logic [LINE_W-1:0] if_rdata,
  input  logic              dr_valid,
  output logic              dr_ready,
  input  logic [ADDR_W-1:0] dr_addr,
  input  logic [2:0]        dr_size,
  output logic              dr_rvalid,
  output logic [LINE_W-1:0] dr_rdata,
  output logic              err_valid,
  output logic [ADDR_W-1:0] err_addr
);
  logic                  wr_full;
  logic                  dr_acc;
  logic                  req;
  logic [2:0]            sz;
  logic [LINE_GRAN-1:0]  gmask;
  logic [GIDX_W-1:0]     rd_start;
  logic [LINE_GRAN-1:0][GRAN_BITS-1:0] rd_data;
  logic [LINE_GRAN-1:0]  rd_par;
  logic [LINE_GRAN-1:0]  rd_vld;
  logic [LINE_W-1:0]     rdata_q;
  logic                  unused_low;

  assign unused_low = ^{if_addr[4:0], dr_addr[2:0]};

  // Fetch always wins; the copy-agent read waits
  assign dr_ready = !if_valid;
  assign dr_acc   = dr_valid && dr_ready;
  assign req      = if_valid || dr_acc;

  assign sz = (dr_size > 3'(MAX_SIZE)) ? 3'(MAX_SIZE) : dr_size;

  always_comb begin
    if (if_valid) begin
      rd_start = {if_addr[ADDR_W-1:5], 2'b00};
      gmask    = '1;
    end else begin
      rd_start = dr_addr[ADDR_W-1:3];
      gmask    = '0;
      if (dr_acc && sz >= 3'(MIN_CHECK)) begin
        for (int k = 0; k < LINE_GRAN; k++) begin
          if (k < (1 << (sz - 3'(MIN_CHECK)))) gmask[k] = 1'b1;
        end
      end
    end
  end

  ipar_wclass #(.ADDR_W(ADDR_W)) u_wclass (
    .addr (wr_addr),
    .be   (wr_be),
    .full (wr_full)
  );

  ipar_store #(.GRAN_CNT(GRAN_CNT)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .prot_en  (prot_en),
    .wr_valid (wr_valid),
    .wr_gidx  (wr_addr[ADDR_W-1:3]),
    .wr_be    (wr_be),
    .wr_data  (wr_data),
    .wr_full  (wr_full),
    .rd_gidx  (rd_start),
    .rd_data  (rd_data),
    .rd_par   (rd_par),
    .rd_vld   (rd_vld)
  );

  ipar_check #(.GIDX_W(GIDX_W)) u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .chk_en    (prot_en),
    .gmask     (gmask),
    .start     (rd_start),
    .rd_data   (rd_data),
    .rd_par    (rd_par),
    .rd_vld    (rd_vld),
    .err_valid (err_valid),
    .err_addr  (err_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if_rvalid <= 1'b0;
      dr_rvalid <= 1'b0;
      rdata_q   <= '0;
    end else begin
      if_rvalid <= if_valid;
      dr_rvalid <= dr_acc;
      if (req) rdata_q <= rd_data;
    end
  end

  assign if_rdata = rdata_q;
  assign dr_rdata = rdata_q;

  // R9: never two responses in one cycle
  a_r9_one_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !(if_rvalid && dr_rvalid));

  // R9: a fetch cycle accepts no copy-agent read
  a_r9_fetch_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    if_valid |=> !dr_rvalid);

  // R8: the error pulse rides on a read response
  a_r8_err_with_resp: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (if_rvalid || dr_rvalid));

  // R4: reads taken with protection off stay silent
  a_r4_off_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> $past(prot_en));
endmodule

// File: tb/sim_ipar_guard.sv
module sim_ipar_guard;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         prot_en;
  logic         wr_valid;
  logic [6:0]   wr_addr;
  logic [7:0]   wr_be;
  logic [63:0]  wr_data;
  logic         if_valid;
  logic [6:0]   if_addr;
  logic         if_rvalid;
  logic [255:0] if_rdata;
  logic         dr_valid;
  logic         dr_ready;
  logic [6:0]   dr_addr;
  logic [2:0]   dr_size;
  logic         dr_rvalid;
  logic [255:0] dr_rdata;
  logic         err_valid;
  logic [6:0]   err_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipar_guard u0 (
    .clk(clk), .rst_n(rst_n), .prot_en(prot_en),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
    .if_valid(if_valid), .if_addr(if_addr), .if_rvalid(if_rvalid), .if_rdata(if_rdata),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr), .dr_size(dr_size),
    .dr_rvalid(dr_rvalid), .dr_rdata(dr_rdata),
    .err_valid(err_valid), .err_addr(err_addr)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [63:0]  m_dat [NG];
  bit           m_par [NG];
  bit           m_vld [NG];
  bit           e_if, e_dr, e_err;
  logic [6:0]   e_ea;
  logic [255:0] e_rd;

  always @(posedge clk) begin
    if (!rst_n) begin
      e_if = 0; e_dr = 0; e_err = 0; e_ea = '0; e_rd = '0;
      for (int g = 0; g < NG; g++) m_vld[g] = 0;
    end else begin
      int st, n, s;
      check(dr_ready === !if_valid, "R9 dr_ready", dr_ready, !if_valid);
      e_if = if_valid;
      e_dr = dr_valid && !if_valid;
      st = if_valid ? int'(if_addr >> 5) * 4 : int'(dr_addr >> 3);
      s  = (dr_size > 5) ? 5 : int'(dr_size);
      n  = if_valid ? 4 : (e_dr && s >= 3) ? (1 << (s - 3)) : 0;
      if (e_if || e_dr)
        for (int k = 0; k < 4; k++) e_rd[64*k +: 64] = m_dat[(st + k) % NG];
      e_err = 0;
      if (prot_en) begin
        for (int k = 0; k < n; k++) begin
          int g;
          g = (st + k) % NG;
          if (!e_err && m_vld[g] && ((^m_dat[g]) != m_par[g])) begin
            e_err = 1;
            e_ea  = 7'(g * 8);
          end
        end
      end
      if (wr_valid) begin
        int g;
        g = int'(wr_addr >> 3);
        for (int b = 0; b < 8; b++)
          if (wr_be[b]) m_dat[g][8*b +: 8] = wr_data[8*b +: 8];
        if (prot_en) begin
          if (wr_be == 8'hFF && wr_addr[2:0] == 3'd0) begin
            m_par[g] = ^wr_data;
            m_vld[g] = 1;
          end else begin
            m_vld[g] = 0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      check(if_rvalid === e_if, "R5 if_rvalid", if_rvalid, e_if);
      check(dr_rvalid === e_dr, "R6 dr_rvalid", dr_rvalid, e_dr);
      check(err_valid === e_err, "R8 err_valid", err_valid, e_err);
      if (e_err) check(err_addr === e_ea, "R8 err_addr", err_addr, e_ea);
      if (e_if) check(if_rdata === e_rd, "R5 if_rdata", if_rdata, e_rd);
      if (e_dr) check(dr_rdata === e_rd, "R6 dr_rdata", dr_rdata, e_rd);
    end
  end

  // ---------------- stimulus helpers (entered just after a negedge) ----
  function automatic logic [63:0] pat(input int g);
    return 64'h0123_4567_89AB_CDEF ^ (64'(g) * 64'h0101_0101_0101_0101);
  endfunction

  task automatic wr(input int a, input logic [7:0] be, input logic [63:0] d);
    wr_valid = 1; wr_addr = 7'(a); wr_be = be; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic fetch(input int a);
    if_valid = 1; if_addr = 7'(a);
    @(negedge clk);
    if_valid = 0;
  endtask

  task automatic dread(input int a, input int s);
    dr_valid = 1; dr_addr = 7'(a); dr_size = 3'(s);
    @(negedge clk);
    dr_valid = 0;
  endtask

  task automatic expect_err(input bit e, input int a, input string tag);
    check(err_valid === e, {tag, " err_valid"}, err_valid, e);
    if (e) check(err_addr === 7'(a), {tag, " err_addr"}, err_addr, a);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; prot_en = 1;
    wr_valid = 0; wr_addr = '0; wr_be = '0; wr_data = '0;
    if_valid = 0; if_addr = '0; dr_valid = 0; dr_addr = '0; dr_size = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: outputs quiet after reset
    check(err_valid === 0, "R1 err_valid", err_valid, 0);
    check(if_rvalid === 0 && dr_rvalid === 0, "R1 rvalid", {if_rvalid, dr_rvalid}, 0);

    // R2: fill every granule with full aligned writes
    for (int g = 0; g < NG; g++) wr(g * 8, 8'hFF, pat(g));
    fetch(0);
    expect_err(0, 0, "R2");
    check(if_rdata === {pat(3), pat(2), pat(1), pat(0)}, "R5 line0",
          if_rdata, {pat(3), pat(2), pat(1), pat(0)});
    fetch(96 + 5);
    expect_err(0, 0, "R5");
    check(if_rdata === {pat(15), pat(14), pat(13), pat(12)}, "R5 line3",
          if_rdata, {pat(15), pat(14), pat(13), pat(12)});

    // R4: a disabled write flips a bit without touching parity
    prot_en = 0;
    wr(16, 8'hFF, pat(2) ^ 64'h80);
    fetch(0);
    expect_err(0, 0, "R4 off");
    prot_en = 1;
    fetch(0);
    expect_err(1, 16, "R4 stale parity");

    // R8: lowest failing granule wins
    prot_en = 0;
    wr(8, 8'hFF, pat(1) ^ (64'd1 << 40));
    prot_en = 1;
    fetch(0);
    expect_err(1, 8, "R8 first");

    // R6: size-dependent checking
    dread(16, 3);  expect_err(1, 16, "R6 s3");
    dread(16, 2);  expect_err(0, 0, "R6 s2");
    dread(24, 4);  expect_err(0, 0, "R6 s4 clean");
    dread(0, 4);   expect_err(1, 8, "R6 s4");
    dread(0, 7);   expect_err(1, 8, "R6 s7");

    // R3 and R7: partial and misaligned writes drop trust
    wr(16, 8'h0F, 64'h1111_2222_3333_4444);
    dread(16, 3);  expect_err(0, 0, "R7 partial");
    check(dr_rdata[63:0] === {pat(2)[63:32] ^ 32'h0, 32'h3333_4444} ||
          dr_rdata[63:0] === {pat(2)[63:32], 32'h3333_4444}, "R3 lanes",
          dr_rdata[63:0], {pat(2)[63:32], 32'h3333_4444});
    wr(9, 8'hFF, 64'hDEAD_BEEF_0000_0001);
    fetch(0);      expect_err(0, 0, "R3 misaligned");

    // R2: repair restores trust
    wr(8, 8'hFF, pat(1));
    wr(16, 8'hFF, pat(2));
    fetch(0);      expect_err(0, 0, "R2 repaired");

    // R10: write and fetch of the same granule in one cycle
    prot_en = 0;
    wr(40, 8'hFF, pat(5) ^ 64'h1);
    prot_en = 1;
    wr_valid = 1; wr_addr = 7'd40; wr_be = 8'hFF; wr_data = pat(5);
    if_valid = 1; if_addr = 7'd32;
    @(negedge clk);
    wr_valid = 0; if_valid = 0;
    expect_err(1, 40, "R10 old");
    fetch(32);     expect_err(0, 0, "R10 new");

    // R9: fetch and copy-agent read together
    prot_en = 0;
    wr(0, 8'hFF, pat(0) ^ 64'h4);
    prot_en = 1;
    if_valid = 1; if_addr = 7'd32;
    dr_valid = 1; dr_addr = 7'd0; dr_size = 3'd3;
    #1 check(dr_ready === 0, "R9 stall", dr_ready, 0);
    @(negedge clk);
    if_valid = 0;
    check(if_rvalid === 1 && dr_rvalid === 0, "R9 fetch first", {if_rvalid, dr_rvalid}, 2'b10);
    expect_err(0, 0, "R9 fetch");
    @(negedge clk);
    dr_valid = 0;
    check(dr_rvalid === 1, "R9 dr later", dr_rvalid, 1);
    expect_err(1, 0, "R9 dr");

    // R6: wrapping read across the top of the array
    dread(112, 5); expect_err(1, 0, "R6 wrap");
    wr(0, 8'hFF, pat(0));

    // R1: mid-run reset clears trust
    prot_en = 0;
    wr(0, 8'hFF, pat(0) ^ 64'h10);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; prot_en = 1;
    fetch(0);      expect_err(0, 0, "R1 reset trust");

    // Random mix against the model
    for (int i = 0; i < 600; i++) begin
      prot_en  = ($urandom % 4) != 0;
      wr_valid = $urandom % 2;
      wr_addr  = 7'($urandom);
      wr_be    = ($urandom % 2) ? 8'hFF : 8'($urandom);
      if (wr_be == 8'hFF && ($urandom % 2)) wr_addr[2:0] = 3'd0;
      wr_data  = {$urandom, $urandom};
      if_valid = ($urandom % 3) == 0;
      if_addr  = 7'($urandom);
      dr_valid = ($urandom % 2);
      dr_addr  = 7'($urandom);
      dr_size  = 3'($urandom);
      @(negedge clk);
    end
    wr_valid = 0; if_valid = 0; dr_valid = 0;
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule